// File: doc/BRIEF.md
# Two-Rank Boundary Cell Chain

This block is a serial chain of boundary cells that sits between a core's pins and the pin pads. Each cell has two storage ranks. The first rank takes a snapshot of its parallel input or takes the bit from its upstream neighbour. The second rank holds a test value that can be driven onto the parallel output. A single mode input chooses whether each cell's parallel output follows its live input or its held test value.

Loading the first rank never touches the parallel path. A tester can therefore sample live pin values and shift them out while the core keeps running. The second rank changes only on an explicit update strobe, so a new pattern can be shifted in fully before it is applied. All ranks are clocked by the test clock and advance only when their enable strobes are high. An active-low asynchronous reset clears both ranks.

The serial path runs from the cell at index `CHAIN_LEN-1`, which takes the serial input, down to cell 0, which drives the serial output.

Top module: `bscan_chain`

## Requirements
- R1: While reset is active and after it is released, every first-rank and second-rank bit is 0. The serial output reads 0, and with mode high the parallel outputs read all zeros.
- R2: With mode low, every parallel output equals its parallel input in the same cycle. This holds whatever the shift, capture and update strobes are doing.
- R3: With mode high, parallel output bit i equals the second-rank bit of cell i.
- R4: On a clock edge with the capture/shift enable high and the shift select low, each cell's first rank loads its parallel input. After that edge the serial output equals parallel input bit 0.
- R5: On a clock edge with the capture/shift enable high and the shift select high, each cell i loads the first-rank bit of cell i+1, and cell `CHAIN_LEN-1` loads the serial input. The serial output is the first-rank bit of cell 0, so a bit presented at the serial input reaches the serial output after exactly `CHAIN_LEN` shift edges.
- R6: On a clock edge with the capture/shift enable low, every first-rank bit keeps its value, whatever the serial input and shift select are.
- R7: On a clock edge with the update strobe high, each second rank loads its cell's first-rank bit. With the update strobe low, the second rank keeps its value through any capture or shift activity.
- R8: When update and capture/shift happen on the same edge, the second rank takes the first-rank value from before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Test clock; all ranks change on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of both ranks |
| shift_sel | input | 1 | 1: first rank takes the serial neighbour; 0: first rank takes the parallel input |
| cap_en | input | 1 | Enable for the first rank (capture or shift) |
| upd_en | input | 1 | Enable for the second rank (copy from the first rank) |
| test_mode | input | 1 | 1: parallel outputs driven from the second rank; 0: pass-through |
| ser_in | input | 1 | Serial input feeding cell CHAIN_LEN-1 |
| pin_in | input | CHAIN_LEN | Parallel inputs, one per cell |
| pin_out | output | CHAIN_LEN | Parallel outputs, one per cell |
| ser_out | output | 1 | Serial output, first-rank bit of cell 0 |

## Verification
A corrupted first-rank bit cannot be seen at the parallel outputs. It shows up only on the serial output, and only after a number of shift edges equal to its distance from cell 0. For this reason every capture is followed by a complete shift-out, and the bit at each position is compared on its own. A wrong second-rank bit is hidden while mode is low. It appears on the very next cycle in which mode is raised, so the bench toggles mode around every update. Where a strobe is supposed to have no effect, the bench checks at the ports after that strobe and before the next one.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

    // Storage of one boundary cell: snapshot/shift rank and held test rank.
    typedef struct packed {
        logic cap;
        logic hold;
    } bscan_cell_t;

    localparam bscan_cell_t BSCAN_CELL_RST = '{cap: 1'b0, hold: 1'b0};

endpackage

// File: rtl/bscan_out_mux.sv
// Parallel output selector of one cell: live input or held test value.
module bscan_out_mux (
    input  logic test_mode,
    input  logic live_in,
    input  logic held_in,
    output logic drv_out
);

    always_comb begin
        drv_out = live_in;
        if (test_mode) begin
            drv_out = held_in;
        end
    end

endmodule

// File: rtl/bscan_cell.sv
// One two-rank boundary cell.
module bscan_cell
    import bscan_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic shift_sel,
    input  logic cap_en,
    input  logic upd_en,
    input  logic test_mode,
    input  logic par_in,
    input  logic scan_in,
    output logic par_out,
    output logic scan_out
);

    bscan_cell_t cell_d, cell_q;
    logic        cap_src;

    // Front-end selection and next-state computation.
    always_comb begin
        cell_d  = cell_q;
        cap_src = shift_sel ? scan_in : par_in;
        if (cap_en) begin
            cell_d.cap = cap_src;
        end
        if (upd_en) begin
            cell_d.hold = cell_q.cap;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cell_q <= BSCAN_CELL_RST;
        end else begin
            cell_q <= cell_d;
        end
    end

    assign scan_out = cell_q.cap;

    bscan_out_mux u_out_mux (
        .test_mode (test_mode),
        .live_in   (par_in),
        .held_in   (cell_q.hold),
        .drv_out   (par_out)
    );

    // R6
    cap_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> $stable(scan_out));

    // R7
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en |=> $stable(cell_q.hold));

    // R8
    hold_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> cell_q.hold == $past(scan_out));

endmodule

// File: rtl/bscan_chain.sv
// Serial chain of two-rank boundary cells; cell 0 drives the serial output.
module bscan_chain #(
    parameter int CHAIN_LEN = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shift_sel,
    input  logic                 cap_en,
    input  logic                 upd_en,
    input  logic                 test_mode,
    input  logic                 ser_in,
    input  logic [CHAIN_LEN-1:0] pin_in,
    output logic [CHAIN_LEN-1:0] pin_out,
    output logic                 ser_out
);

    localparam int LAST = CHAIN_LEN - 1;

    logic [CHAIN_LEN-1:0] scan_vec;
    logic [CHAIN_LEN-1:0] link_in;

    for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_cell
        if (i == LAST) begin : g_head
            assign link_in[i] = ser_in;
        end else begin : g_body
            assign link_in[i] = scan_vec[i+1];
        end

        bscan_cell u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .shift_sel (shift_sel),
            .cap_en    (cap_en),
            .upd_en    (upd_en),
            .test_mode (test_mode),
            .par_in    (pin_in[i]),
            .scan_in   (link_in[i]),
            .par_out   (pin_out[i]),
            .scan_out  (scan_vec[i])
        );
    end

    assign ser_out = scan_vec[0];

    // R4
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en && !shift_sel) |=> scan_vec == $past(pin_in));

    // R5
    head_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en && shift_sel) |=> scan_vec[LAST] == $past(ser_in));

    if (CHAIN_LEN > 1) begin : g_mid_chk
        // R5
        tail_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cap_en && shift_sel) |=> ser_out == $past(scan_vec[1]));
    end

endmodule

// File: tb/bscan_chain_tb.sv
module bscan_chain_tb;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         shift_sel = 1'b0;
    logic         cap_en = 1'b0;
    logic         upd_en = 1'b0;
    logic         test_mode = 1'b0;
    logic         ser_in = 1'b0;
    logic [N-1:0] pin_in = '0;
    logic [N-1:0] pin_out;
    logic         ser_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [N-1:0] exp_hold = '0;
    logic [N-1:0] exp_cap  = '0;

    always #10 clk = ~clk;

    bscan_chain #(.CHAIN_LEN(N)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_sel (shift_sel),
        .cap_en    (cap_en),
        .upd_en    (upd_en),
        .test_mode (test_mode),
        .ser_in    (ser_in),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .ser_out   (ser_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One rising edge; inputs settle 1 ns after it.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Compare the held rank through the parallel outputs, then restore mode.
    task automatic peek_hold(input string req);
        logic keep;
        keep = test_mode;
        test_mode = 1'b1;
        #1;
        chk(req, 32'(pin_out), 32'(exp_hold));
        test_mode = keep;
        #1;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        test_mode = 1'b1;
        pin_in = 8'hA5;
        #25;
        chk("R1 ser_out in reset", 32'(ser_out), 0);
        chk("R1 pin_out in reset", 32'(pin_out), 0);
        rst_n = 1'b1;
        tick();
        chk("R1 ser_out after reset", 32'(ser_out), 0);
        chk("R1 pin_out after reset", 32'(pin_out), 0);
        test_mode = 1'b0;

        // R2: pass-through sweep
        for (int v = 0; v < 256; v++) begin
            pin_in = 8'(v);
            #1;
            chk("R2 pass-through", 32'(pin_out), 32'(v));
        end

        // Exhaustive capture, shift-out, shift-in, update
        for (int v = 0; v < 256; v++) begin
            logic [N-1:0] w;
            w = 8'((v * 37 + 11) & 255);
            pin_in = 8'(v);
            shift_sel = 1'b0;
            cap_en = 1'b1;
            tick();
            exp_cap = 8'(v);
            chk("R4 capture bit0 on ser_out", 32'(ser_out), 32'(v & 1));
            pin_in = ~8'(v);
            shift_sel = 1'b1;
            for (int s = 1; s <= N; s++) begin
                ser_in = w[s-1];
                tick();
                if (s < N)
                    chk("R5 shift-out of captured bit", 32'(ser_out), 32'((v >> s) & 1));
                else
                    chk("R5 N-edge latency", 32'(ser_out), 32'(w[0]));
                chk("R2 parallel path during shift", 32'(pin_out), 32'(pin_in));
            end
            exp_cap = w;
            peek_hold("R7 hold unchanged by shift");
            cap_en = 1'b0;
            upd_en = 1'b1;
            tick();
            upd_en = 1'b0;
            exp_hold = w;
            chk("R2 parallel path after update", 32'(pin_out), 32'(pin_in));
            test_mode = 1'b1;
            #1;
            chk("R3 held value driven", 32'(pin_out), 32'(w));
            test_mode = 1'b0;
            // R6: idle edges with toggling serial input leave the rank alone
            ser_in = ~w[0];
            tick();
            ser_in = w[0];
            tick();
            chk("R6 no change while disabled", 32'(ser_out), 32'(w[0]));
            cap_en = 1'b1;
            ser_in = 1'b0;
            for (int k = 1; k < N; k++) begin
                tick();
                chk("R5 shifted-in pattern", 32'(ser_out), 32'(w[k]));
            end
            cap_en = 1'b0;
            exp_cap = 8'(w >> (N - 1));
            peek_hold("R7 hold unchanged after second shift");
        end

        // R8: update and capture on the same edge
        shift_sel = 1'b0;
        pin_in = 8'h3C;
        cap_en = 1'b1;
        tick();
        pin_in = 8'hC5;
        upd_en = 1'b1;
        tick();
        cap_en = 1'b0;
        upd_en = 1'b0;
        exp_hold = 8'h3C;
        peek_hold("R8 hold takes pre-edge capture");
        chk("R8 capture took new input", 32'(ser_out), 32'(1));
        shift_sel = 1'b1;
        cap_en = 1'b1;
        for (int k = 1; k < N; k++) begin
            tick();
            chk("R8 new capture shifted out", 32'(ser_out), 32'((8'hC5 >> k) & 1));
        end
        cap_en = 1'b0;

        // R1: reset clears both ranks again
        rst_n = 1'b0;
        #3;
        exp_hold = '0;
        peek_hold("R1 hold cleared by reset");
        chk("R1 capture cleared by reset", 32'(ser_out), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule